// File: doc/BRIEF.md
# Next Fetch Address Sequencer

This block owns the program counter of a simple 32-bit in-order fetch stage and picks, once per clock, the address of the next instruction to fetch. The instruction fetched at the current PC is presented on `instr_i` together with the two register operands that the register file reads for it. From these the block chooses one of four successors:
- the next sequential word;
- a PC-relative branch target taken when the operands are equal or not equal;
- a region-relative jump target built from a 26-bit word index;
- a register-held address.

For call instructions the block also raises a registered write request to the register file. The request carries the return address, which is the address of the word after the call, and the index of the link register.

The PC register updates on every rising clock edge. A synchronous active-high reset returns it to the start-up address. All outputs come straight from flops, so the fetch memory and the register file see stable values for the whole cycle.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes `RESET_PC` (default 0x0040_0000) and `link_we_o` becomes 0; both values are visible in the cycle after reset is released.
- R2: Let the opcode be `instr_i[31:26]` and the function code be `instr_i[5:0]`. An instruction whose opcode is not 2, 3, 4 or 5, and that is not opcode 0 with function code 8, advances the PC to PC+4 at the next edge.
- R3: Opcode 4 (branch on equal) with `rs_val_i == rt_val_i` loads PC+4 + sign-extended `instr_i[15:0]` × 4. For example, an offset of 25 lands 100 bytes past PC+4.
- R4: Opcode 5 (branch on not equal) with `rs_val_i != rt_val_i` loads the same PC-relative target as R3.
- R5: A branch whose condition fails loads PC+4: opcode 4 with unequal operands, or opcode 5 with equal operands.
- R6: The 16-bit offset is signed. When `instr_i[15]` is 1, the target lies below PC+4 (a backward branch).
- R7: Opcode 2 (jump) loads `{PC+4[31:28], instr_i[25:0], 2'b00}`. For example, a field of 20000 reaches byte address 80000 while the upper nibble is 0.
- R8: Opcode 3 (call) loads the same target as R7. In the following cycle it also drives `link_we_o`=1, `link_data_o` = the call's PC+4 and `link_addr_o` = 31.
- R9: Opcode 0 with function code 8 (register jump) loads `rs_val_i` unchanged.
- R10: `link_we_o` is 0 in every cycle that does not follow a call, and this includes the cycles after a jump or a register jump.
- R11: The upper four bits of a region jump come from PC+4 and not from PC. For example, a jump sitting at 0x0FFF_FFFC with field 5 goes to 0x1000_0014.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word fetched at `pc_o` |
| rs_val_i | input | XLEN | Value read for the first source register |
| rt_val_i | input | XLEN | Value read for the second source register |
| pc_o | output | XLEN | Current program counter |
| link_we_o | output | 1 | Registered request to write the link register |
| link_addr_o | output | REG_IDX_W | Index of the register to write (LINK_REG) |
| link_data_o | output | XLEN | Return address for the link write |

## Verification
The bench builds the block with its defaults: XLEN 32, the start-up address 0x0040_0000 and link register 31. With these values, every successor form can be reached from the start-up region. A register jump carries the PC to the last word below a 256 MB boundary, so a region jump placed there shows whether the upper address bits are taken from PC+4. Random runs mix branches with equal and unequal operands and with offsets of both signs, jumps, calls, register jumps and ordinary instructions. They also cover the cycle after each call, when the link write must appear, and the cycle after every other instruction, when it must not.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int INSN_W   = 32;
  localparam int OPC_W    = 6;
  localparam int OFFS_W   = 16;
  localparam int JIDX_W   = 26;
  localparam int FN_W     = 6;
  localparam int WORD_SH  = 2;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_CALL    = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'd5;
  localparam logic [FN_W-1:0]  FN_REGJUMP  = 6'd8;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_REGION = 2'd2,
    SEL_REG    = 2'd3
  } tgt_sel_e;

  typedef struct packed {
    tgt_sel_e sel;
    logic     link;
  } flow_t;
endpackage

// File: rtl/pc_flow_decode.sv
module pc_flow_decode
  import pc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSN_W-1:0] instr,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output flow_t             flow
);
  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;
  logic             operands_eq;

  assign opc         = instr[INSN_W-1 -: OPC_W];
  assign fn          = instr[FN_W-1:0];
  assign operands_eq = (rs_val == rt_val);

  always_comb begin
    flow.sel  = SEL_SEQ;
    flow.link = 1'b0;
    unique case (opc)
      OPC_BR_EQ:   if (operands_eq)  flow.sel = SEL_BRANCH;
      OPC_BR_NE:   if (!operands_eq) flow.sel = SEL_BRANCH;
      OPC_JUMP:    flow.sel = SEL_REGION;
      OPC_CALL: begin
        flow.sel  = SEL_REGION;
        flow.link = 1'b1;
      end
      OPC_SPECIAL: if (fn == FN_REGJUMP) flow.sel = SEL_REG;
      default:     flow.sel = SEL_SEQ;
    endcase
  end
endmodule

// File: rtl/pc_target_calc.sv
module pc_target_calc
  import pc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [INSN_W-1:0] instr,
  input  logic [XLEN-1:0]   rs_val,
  output logic [XLEN-1:0]   seq_tgt,
  output logic [XLEN-1:0]   branch_tgt,
  output logic [XLEN-1:0]   region_tgt,
  output logic [XLEN-1:0]   reg_tgt
);
  localparam int EXT_W = XLEN - OFFS_W - WORD_SH;
  localparam int HI_W  = XLEN - JIDX_W - WORD_SH;
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << WORD_SH);

  logic [XLEN-1:0] offs_bytes;

  assign seq_tgt    = pc + STEP;
  assign offs_bytes = {{EXT_W{instr[OFFS_W-1]}}, instr[OFFS_W-1:0], {WORD_SH{1'b0}}};
  assign branch_tgt = seq_tgt + offs_bytes;
  assign region_tgt = {seq_tgt[XLEN-1 -: HI_W], instr[JIDX_W-1:0], {WORD_SH{1'b0}}};
  assign reg_tgt    = rs_val;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_PC  = 32'h0040_0000,
  parameter int              REG_IDX_W = 5,
  parameter int              LINK_REG  = 31
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INSN_W-1:0]    instr_i,
  input  logic [XLEN-1:0]      rs_val_i,
  input  logic [XLEN-1:0]      rt_val_i,
  output logic [XLEN-1:0]      pc_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_addr_o,
  output logic [XLEN-1:0]      link_data_o
);
  flow_t           flow;
  logic [XLEN-1:0] seq_tgt, branch_tgt, region_tgt, reg_tgt;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_q;
  logic            link_we_q;
  logic [XLEN-1:0] link_data_q;

  pc_flow_decode #(.XLEN(XLEN)) u_decode (
    .instr  (instr_i),
    .rs_val (rs_val_i),
    .rt_val (rt_val_i),
    .flow   (flow)
  );

  pc_target_calc #(.XLEN(XLEN)) u_targets (
    .pc         (pc_q),
    .instr      (instr_i),
    .rs_val     (rs_val_i),
    .seq_tgt    (seq_tgt),
    .branch_tgt (branch_tgt),
    .region_tgt (region_tgt),
    .reg_tgt    (reg_tgt)
  );

  always_comb begin
    unique case (flow.sel)
      SEL_BRANCH: pc_d = branch_tgt;
      SEL_REGION: pc_d = region_tgt;
      SEL_REG:    pc_d = reg_tgt;
      default:    pc_d = seq_tgt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= RESET_PC;
      link_we_q   <= 1'b0;
      link_data_q <= '0;
    end else begin
      pc_q        <= pc_d;
      link_we_q   <= flow.link;
      link_data_q <= seq_tgt;
    end
  end

  assign pc_o        = pc_q;
  assign link_we_o   = link_we_q;
  assign link_data_o = link_data_q;
  assign link_addr_o = REG_IDX_W'(LINK_REG);
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_PC  = 32'h0040_0000,
  parameter int              REG_IDX_W = 5,
  parameter int              LINK_REG  = 31
) (
  input logic                 clk,
  input logic                 rst,
  input logic [31:0]          instr_i,
  input logic [XLEN-1:0]      rs_val_i,
  input logic [XLEN-1:0]      rt_val_i,
  input logic [XLEN-1:0]      pc_o,
  input logic                 link_we_o,
  input logic [REG_IDX_W-1:0] link_addr_o,
  input logic [XLEN-1:0]      link_data_o
);
  logic seen_rst;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  logic [5:0] op;
  logic       is_call, is_regj, is_ctrl;
  logic [XLEN-1:0] boffs;
  assign op      = instr_i[31:26];
  assign is_call = (op == 6'd3);
  assign is_regj = (op == 6'd0) && (instr_i[5:0] == 6'd8);
  assign is_ctrl = is_call || is_regj || (op == 6'd2) || (op == 6'd4) || (op == 6'd5);
  assign boffs   = {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!seen_rst)
    $fell(rst) |-> (pc_o == RESET_PC) && !link_we_o);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !is_ctrl |=> pc_o == $past(pc_o) + XLEN'(4));

  assert_beq_taken_R3: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (op == 6'd4) && (rs_val_i == rt_val_i) |=> pc_o == $past(pc_o) + XLEN'(4) + $past(boffs));

  assert_bne_untaken_R5: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (op == 6'd5) && (rs_val_i == rt_val_i) |=> pc_o == $past(pc_o) + XLEN'(4));

  assert_call_link_R8: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    is_call |=> link_we_o && (link_data_o == $past(pc_o) + XLEN'(4))
                && (link_addr_o == REG_IDX_W'(LINK_REG)));

  assert_regjump_R9: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    is_regj |=> pc_o == $past(rs_val_i));

  assert_no_link_R10: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !is_call |=> !link_we_o);
endmodule

bind pc_sequencer pc_seq_chk #(
  .XLEN(XLEN), .RESET_PC(RESET_PC), .REG_IDX_W(REG_IDX_W), .LINK_REG(LINK_REG)
) u_chk (.*);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  localparam logic [31:0] RST_PC = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = 32'd0;
  logic [31:0] rs_val_i = 32'd0;
  logic [31:0] rt_val_i = 32'd0;
  logic [31:0] pc_o;
  logic        link_we_o;
  logic [4:0]  link_addr_o;
  logic [31:0] link_data_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rst(rst), .instr_i(instr_i), .rs_val_i(rs_val_i),
    .rt_val_i(rt_val_i), .pc_o(pc_o), .link_we_o(link_we_o),
    .link_addr_o(link_addr_o), .link_data_o(link_data_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_pc(input logic [31:0] pc, input logic [31:0] ins,
                                            input logic [31:0] a, input logic [31:0] b);
    logic [31:0] nxt;
    logic [31:0] off;
    nxt = pc + 32'd4;
    off = 32'($signed(ins[15:0])) * 32'sd4;
    case (ins[31:26])
      6'd4:    return (a == b) ? nxt + off : nxt;
      6'd5:    return (a != b) ? nxt + off : nxt;
      6'd2, 6'd3: return {nxt[31:28], 28'(ins[25:0]) << 2};
      6'd0:    return (ins[5:0] == 6'd8) ? a : nxt;
      default: return nxt;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    case (ins[31:26])
      6'd4:    return (a == b) ? (ins[15] ? "R6" : "R3") : "R5";
      6'd5:    return (a != b) ? (ins[15] ? "R6" : "R4") : "R5";
      6'd2:    return "R7";
      6'd3:    return "R8";
      6'd0:    return (ins[5:0] == 6'd8) ? "R9" : "R2";
      default: return "R2";
    endcase
  endfunction

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    bit          call;
    string       tag;
    exp  = expect_pc(model_pc, ins, a, b);
    call = (ins[31:26] == 6'd3);
    tag  = tag_of(ins, a, b);
    instr_i = ins; rs_val_i = a; rt_val_i = b;
    @(negedge clk);
    chk(pc_o == exp, tag, pc_o, exp);
    if (call) begin
      chk(link_we_o == 1'b1, "R8", {31'd0, link_we_o}, 32'd1);
      chk(link_data_o == model_pc + 32'd4, "R8", link_data_o, model_pc + 32'd4);
      chk(link_addr_o == 5'd31, "R8", {27'd0, link_addr_o}, 32'd31);
    end else begin
      chk(link_we_o == 1'b0, "R10", {31'd0, link_we_o}, 32'd0);
    end
    model_pc = exp;
  endtask

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [25:0] rest);
    return {op, rest};
  endfunction

  initial begin
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(pc_o == RST_PC, "R1", pc_o, RST_PC);
    chk(link_we_o == 1'b0, "R1", {31'd0, link_we_o}, 32'd0);
    model_pc = RST_PC;

    // R2: register add (function 32) and a load step sequentially
    step(mk_i(6'd0, 26'h0232020), 32'd7, 32'd9);
    step(mk_i(6'd35, 26'h1234), 32'd1, 32'd1);
    // R3: equal operands, offset 25 -> 100 bytes past PC+4
    step(mk_i(6'd4, {10'd0, 16'd25}), 32'hAB, 32'hAB);
    // R4: unequal operands with not-equal branch
    step(mk_i(6'd5, {10'd0, 16'd8}), 32'd1, 32'd2);
    // R5: both branch kinds not taken
    step(mk_i(6'd4, {10'd0, 16'd40}), 32'd1, 32'd2);
    step(mk_i(6'd5, {10'd0, 16'd40}), 32'd5, 32'd5);
    // R6: backward branch, offset -3
    step(mk_i(6'd4, {10'd0, 16'hFFFD}), 32'd0, 32'd0);
    // R7: jump field 20000 -> 80000
    step(mk_i(6'd2, 26'd20000), 32'd0, 32'd0);
    chk(pc_o == 32'd80000, "R7", pc_o, 32'd80000);
    // R8: call, link appears in the following cycle
    step(mk_i(6'd3, 26'd300), 32'd0, 32'd0);
    // R10: ordinary instruction after call drops the link request
    step(mk_i(6'd8, 26'd4), 32'd0, 32'd0);
    // R9: register jump to a boundary word
    step(mk_i(6'd0, {5'd31, 15'd0, 6'd8}), 32'h0FFF_FFFC, 32'd0);
    // R11: upper nibble comes from PC+4
    step(mk_i(6'd2, 26'd5), 32'd0, 32'd0);
    chk(pc_o == 32'h1000_0014, "R11", pc_o, 32'h1000_0014);

    // R1: reset in mid-run, right after a call
    step(mk_i(6'd3, 26'd77), 32'd0, 32'd0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(pc_o == RST_PC, "R1", pc_o, RST_PC);
    chk(link_we_o == 1'b0, "R1", {31'd0, link_we_o}, 32'd0);
    rst = 1'b0;
    model_pc = RST_PC;

    for (int n = 0; n < 600; n++) begin
      logic [31:0] ins, a, b;
      logic [15:0] imm;
      imm = 16'($urandom);
      a   = $urandom;
      b   = ($urandom % 2 == 0) ? a : $urandom;
      case ($urandom % 7)
        0: ins = mk_i(6'd4, {10'($urandom), imm});
        1: ins = mk_i(6'd5, {10'($urandom), imm});
        2: ins = mk_i(6'd2, 26'($urandom));
        3: ins = mk_i(6'd3, 26'($urandom));
        4: begin ins = mk_i(6'd0, {20'($urandom), 6'd8}); a = a & ~32'd3; end
        5: ins = mk_i(6'd0, {20'($urandom), 6'd32});
        default: ins = mk_i(6'd35, 26'($urandom));
      endcase
      step(ins, a, b);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule